// File: doc/BRIEF.md
# Two-parallel fast FIR filter

This block is a block-processing FIR filter. Each clock it can take two new input samples and return two filtered output samples, so the sample rate is twice the clock rate. Input `x0` carries the earlier sample of each pair (full-rate index 2k) and `x1` carries the later one (index 2k+1). The block returns the two matching outputs of an ordinary N-tap convolution on `y0` and `y1`. The taps are split into an even-indexed half and an odd-indexed half. Three half-length subfilters replace the four that a plain two-parallel form needs, because the even-on-even and odd-on-odd partial results are shared between both outputs through one pre-addition and a few post-additions.

The coefficients are fixed when the block is built. A parameter selects the arithmetic arrangement:
- The plain fast form uses subfilters on the even taps, the odd taps and their sum.
- The symmetric form uses subfilters on the sum of the two halves, the difference of the two halves and the odd taps, and divides by two exactly at the end.

A second parameter selects how each subfilter sums its products: a ripple adder chain, or a carry-save chain with one final add. All four combinations give identical results. Internal arithmetic keeps full precision, and the outputs are wide enough that no input or coefficient value can overflow them.

Top module: `fir2p_fast`

## Requirements
- R1: With tap i of `COEFS` held signed at bits [i*CW +: CW], and the pair (x0, x1) of valid block k taken as full-rate samples x[2k] and x[2k+1], `y0` equals the sum over i of h[i]*x[2k-i] and `y1` equals the sum over i of h[i]*x[2k+1-i]. Samples before reset count as zero.
- R2: The odd-tap contribution of the previous valid block's `x1` appears in the next block's `y0`. An impulse on `x1` shows up in `y1` of its own block and in `y0` of the following block.
- R3: Full-scale inputs, including -2^(DW-1) on both lanes together with extreme coefficients, give exact results with no wrap-around.
- R4: `out_valid` equals `in_valid` delayed by exactly two clocks. The outputs of a block are present in the cycle where its `out_valid` is high.
- R5: The delay lines advance only when `in_valid` is high. Sample values presented while `in_valid` is low have no effect on any later output.
- R6: While `out_valid` is low, `y0` and `y1` hold their last values.
- R7: With `ARCH`=1 (symmetric form), the outputs are bit-identical to those of the convolution in R1.
- R8: With `ADDER`=1 (carry-save summation), the outputs are bit-identical to those of the convolution in R1.
- R9: Synchronous reset (`rst` high at a rising edge) clears `out_valid`, both outputs and all sample history. The first outputs after reset therefore treat all earlier samples as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | The input pair is valid this clock |
| x0 | input | DW | Earlier sample of the pair (index 2k), signed |
| x1 | input | DW | Later sample of the pair (index 2k+1), signed |
| out_valid | output | 1 | The output pair is valid this clock |
| y0 | output | OW | Output for index 2k, signed, OW = DW+CW+3+clog2(NTAPS/2) |
| y1 | output | OW | Output for index 2k+1, signed |

## Verification
The bench goes after the cross-block term first, with separate impulses on each lane. A design that dropped or mistimed the delayed odd-on-odd product would get `y0` wrong one block after an `x1` impulse, while the `x0` impulse still looked correct. It also drives long runs of the most negative input against the most negative and most positive coefficients. Any subfilter sum or pre-added sample kept one bit too narrow would wrap and produce a sign-flipped output. Random gaps in `in_valid`, carrying junk sample values, expose delay lines that shift on every clock; they also expose a delayed product register that updates without a valid block, which would scramble the outputs after a gap. The same stimulus runs through the symmetric and carry-save variants, where an inexact halving or a lost carry shows up as an off-by-one or off-by-power-of-two miscompare.

// File: rtl/fir2p_fast.sv
module fir2p_fast #(
  parameter int DW = 16,
  parameter int CW = 12,
  parameter int NTAPS = 8,
  parameter logic [NTAPS*CW-1:0] COEFS = {12'h011, 12'hFE2, 12'h040, 12'h07B,
                                          12'h07B, 12'h040, 12'hFE2, 12'h011},
  parameter int ARCH = 0,
  parameter int ADDER = 0,
  localparam int M = NTAPS / 2,
  localparam int OW = DW + CW + 3 + $clog2(M)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] x0,
  input  logic signed [DW-1:0] x1,
  output logic                 out_valid,
  output logic signed [OW-1:0] y0,
  output logic signed [OW-1:0] y1
);

  localparam int XW = DW + 1;

  function automatic logic signed [CW:0] tapc(int sel, int j);
    logic signed [CW-1:0] he, ho;
    logic signed [CW:0] e1, o1;
    he = COEFS[(2*j)*CW +: CW];
    ho = COEFS[(2*j+1)*CW +: CW];
    e1 = he;
    o1 = ho;
    case (sel)
      0:       return e1;
      1:       return o1;
      2:       return e1 + o1;
      default: return e1 - o1;
    endcase
  endfunction

  function automatic int pick(int k);
    return (ARCH == 1 && k == 0) ? 3 : k;
  endfunction

  logic signed [XW-1:0] xe0, xe1;
  logic signed [XW-1:0] lin [3];
  logic signed [XW-1:0] hist [3][M-1];
  logic signed [OW-1:0] fsum [3];
  logic signed [OW-1:0] fq [3];
  logic signed [OW-1:0] odd_prev, p0, p1;
  logic v1;

  assign xe0 = x0;
  assign xe1 = x1;

  always_comb begin
    lin[0] = (ARCH == 1) ? xe0 - xe1 : xe0;
    lin[1] = xe1;
    lin[2] = xe0 + xe1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < 3; k++)
        for (int j = 0; j < M-1; j++) hist[k][j] <= '0;
    end else if (in_valid) begin
      for (int k = 0; k < 3; k++) begin
        hist[k][0] <= lin[k];
        for (int j = 1; j < M-1; j++) hist[k][j] <= hist[k][j-1];
      end
    end
  end

  for (genvar k = 0; k < 3; k++) begin : g_sub
    logic signed [OW-1:0] term [M];
    logic signed [OW-1:0] acc;
    for (genvar j = 0; j < M; j++) begin : g_tap
      localparam logic signed [CW:0] KC = tapc(pick(k), j);
      logic signed [XW-1:0] tv;
      if (j == 0) begin : g_now
        assign tv = lin[k];
      end else begin : g_old
        assign tv = hist[k][j-1];
      end
      assign term[j] = OW'(tv) * OW'(KC);
    end
    if (ADDER == 0) begin : g_rca
      always_comb begin
        acc = '0;
        for (int j = 0; j < M; j++) acc = acc + term[j];
      end
    end else begin : g_csa
      always_comb begin
        logic signed [OW-1:0] s, c, ns, nc;
        s = '0;
        c = '0;
        for (int j = 0; j < M; j++) begin
          ns = s ^ c ^ term[j];
          nc = ((s & c) | (s & term[j]) | (c & term[j])) << 1;
          s = ns;
          c = nc;
        end
        acc = s + c;
      end
    end
    assign fsum[k] = acc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      for (int k = 0; k < 3; k++) fq[k] <= '0;
    end else begin
      v1 <= in_valid;
      if (in_valid)
        for (int k = 0; k < 3; k++) fq[k] <= fsum[k];
    end
  end

  always_comb begin
    if (ARCH == 1) begin
      p0 = ((fq[2] + fq[0]) >>> 1) - fq[1] + odd_prev;
      p1 = (fq[2] - fq[0]) >>> 1;
    end else begin
      p0 = fq[0] + odd_prev;
      p1 = fq[2] - fq[0] - fq[1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      y0        <= '0;
      y1        <= '0;
      odd_prev  <= '0;
    end else begin
      out_valid <= v1;
      if (v1) begin
        y0       <= p0;
        y1       <= p1;
        odd_prev <= fq[1];
      end
    end
  end

endmodule

module fir2p_fast_chk #(
  parameter int OW = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic                 out_valid,
  input logic signed [OW-1:0] y0,
  input logic signed [OW-1:0] y1
);

  logic [1:0] cnt;
  logic       vin_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      vin_d <= 1'b0;
    end else begin
      cnt   <= (cnt == 2'd2) ? cnt : cnt + 2'd1;
      vin_d <= in_valid;
    end
  end

  // R4
  lat_match_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt == 2'd2) |-> (out_valid == $past(in_valid, 2)));

  // R9
  early_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt != 2'd2) |-> !out_valid);

  // R9
  rst_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt == 2'd0) |-> (y0 == '0 && y1 == '0));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt != 2'd0 && !vin_d) |=> ($stable(y0) && $stable(y1)));

endmodule

bind fir2p_fast fir2p_fast_chk #(.OW(OW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid),
  .out_valid(out_valid), .y0(y0), .y1(y1)
);

// File: tb/sim_fir2p_fast.sv
module sim_fir2p_fast;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int CW = 12;
  localparam int NT = 8;
  localparam int OW = DW + CW + 3 + $clog2(NT/2);
  localparam int HC [NT] = '{-2048, 2047, 731, -1290, 455, 1999, -2048, -17};

  function automatic logic [NT*CW-1:0] packc();
    logic [NT*CW-1:0] r;
    for (int i = 0; i < NT; i++) r[i*CW +: CW] = HC[i][CW-1:0];
    return r;
  endfunction

  localparam logic [NT*CW-1:0] CP = packc();

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [DW-1:0] x0 = '0, x1 = '0;
  logic ov [3];
  logic signed [OW-1:0] ya [3];
  logic signed [OW-1:0] yb [3];

  always #(CLK_PERIOD/2) clk = ~clk;

  fir2p_fast #(.DW(DW), .CW(CW), .NTAPS(NT), .COEFS(CP), .ARCH(0), .ADDER(0)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .x0(x0), .x1(x1),
    .out_valid(ov[0]), .y0(ya[0]), .y1(yb[0]));
  fir2p_fast #(.DW(DW), .CW(CW), .NTAPS(NT), .COEFS(CP), .ARCH(1), .ADDER(1)) u1 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .x0(x0), .x1(x1),
    .out_valid(ov[1]), .y0(ya[1]), .y1(yb[1]));
  fir2p_fast #(.DW(DW), .CW(CW), .NTAPS(NT), .COEFS(CP), .ARCH(0), .ADDER(1)) u2 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .x0(x0), .x1(x1),
    .out_valid(ov[2]), .y0(ya[2]), .y1(yb[2]));

  int vectors = 0;
  int misses = 0;
  longint xh [NT];
  bit pv [2];
  longint pe0 [2], pe1 [2];
  string pt [2];
  longint last0 = 0, last1 = 0;
  string phase = "R1";

  task automatic chk(string req, string what, longint act, longint exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint push(longint v);
    longint s = 0;
    for (int i = NT-1; i > 0; i--) xh[i] = xh[i-1];
    xh[0] = v;
    for (int i = 0; i < NT; i++) s += longint'(HC[i]) * xh[i];
    return s;
  endfunction

  task automatic compare();
    longint e0, e1;
    string tg;
    e0 = pv[1] ? pe0[1] : last0;
    e1 = pv[1] ? pe1[1] : last1;
    chk("R4", "u0 out_valid", longint'(ov[0]), longint'(pv[1]));
    chk("R7", "u1 out_valid", longint'(ov[1]), longint'(pv[1]));
    tg = pv[1] ? pt[1] : "R6";
    chk(tg, "u0 y0", longint'(ya[0]), e0);
    chk(tg, "u0 y1", longint'(yb[0]), e1);
    chk("R7", "u1 y0", longint'(ya[1]), e0);
    chk("R7", "u1 y1", longint'(yb[1]), e1);
    chk("R8", "u2 y0", longint'(ya[2]), e0);
    chk("R8", "u2 y1", longint'(yb[2]), e1);
    if (pv[1]) begin
      last0 = pe0[1];
      last1 = pe1[1];
    end
  endtask

  task automatic step(bit v, longint a, longint b);
    @(negedge clk);
    compare();
    in_valid = v;
    x0 = DW'(a);
    x1 = DW'(b);
    pv[1] = pv[0];
    pe0[1] = pe0[0];
    pe1[1] = pe1[0];
    pt[1] = pt[0];
    pv[0] = v;
    pt[0] = phase;
    if (v) begin
      pe0[0] = push(a);
      pe1[0] = push(b);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    for (int d = 0; d < 3; d++) begin
      chk("R9", "out_valid in reset", longint'(ov[d]), 0);
      chk("R9", "y0 in reset", longint'(ya[d]), 0);
      chk("R9", "y1 in reset", longint'(yb[d]), 0);
    end
    for (int i = 0; i < NT; i++) xh[i] = 0;
    pv[0] = 0;
    pv[1] = 0;
    last0 = 0;
    last1 = 0;
    rst = 1'b0;
  endtask

  function automatic longint rs();
    if ($urandom % 8 == 0) return -32768;
    return longint'($signed(16'($urandom)));
  endfunction

  initial begin
    for (int i = 0; i < NT; i++) xh[i] = 0;
    pv[0] = 0;
    pv[1] = 0;
    pt[0] = "R1";
    pt[1] = "R1";
    do_reset();
    phase = "R1";
    step(1, 1000, 0);
    for (int i = 0; i < 6; i++) step(1, 0, 0);
    phase = "R2";
    step(1, 0, 1000);
    for (int i = 0; i < 6; i++) step(1, 0, 0);
    phase = "R1";
    for (int i = 0; i < 8; i++) step(1, 12345, 12345);
    phase = "R3";
    for (int i = 0; i < 10; i++) step(1, -32768, -32768);
    for (int i = 0; i < 6; i++) step(1, 32767, -32768);
    phase = "R5";
    step(1, 500, -700);
    for (int i = 0; i < 3; i++) step(0, 9999, -9999);
    for (int i = 0; i < 5; i++) step(1, 0, 0);
    phase = "R1";
    for (int i = 0; i < 300; i++) step(1, rs(), rs());
    phase = "R5";
    for (int i = 0; i < 400; i++) step(($urandom % 4) != 0, rs(), rs());
    do_reset();
    phase = "R9";
    for (int i = 0; i < 5; i++) step(1, 0, 0);
    phase = "R1";
    for (int i = 0; i < 100; i++) step(1, rs(), rs());
    for (int i = 0; i < 3; i++) step(0, 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule